// File: doc/BRIEF.md
# Priority Request/Response Coherence Message Queue

This block carries coherence traffic between a private data cache and its parent controller. Two classes of message share it: requests (a target MSI state for a line) and responses (the resulting MSI state, optionally with line data). Each class has its own enqueue port and its own internal queue of equal, configurable depth. A single head port presents one message at a time, and a single dequeue strobe removes it.

Responses always take precedence at the head. While any response is waiting, the head shows the oldest response. The request queue is served only when the response queue is empty. A backlog of requests therefore never delays a response, which is what keeps the coherence protocol free of deadlock. Per-class presence flags let the consumer see which classes are waiting without dequeuing.

A request has a child ID, a line address and an MSI state. A response has the same three fields plus a line-data word qualified by its own valid bit. MSI states are encoded in 2 bits: I = 0, S = 1, M = 2.

Top module: `coh_msg_queue`

## Requirements
- R1: Requests accepted on the request port leave the head in the order they were accepted, with child, address and state unchanged.
- R2: Responses accepted on the response port leave the head in the order they were accepted, with child, address, state, data-valid and data unchanged.
- R3: While the response queue holds any entry, the head shows the oldest response with head_is_rsp_o = 1. Only when it is empty does the head show the oldest request, with head_is_rsp_o = 0.
- R4: A dequeue removes the head entry from the response queue if that queue is non-empty, and otherwise from the request queue. A response accepted after several requests is dequeued before all of them.
- R5: has_rsp_o and has_req_o are 1 exactly when the respective queue is non-empty, and not_empty_o is their OR. All three are 0 after reset.
- R6: Each queue holds DEPTH entries. Each port's ready output is 0 exactly when its own queue is full, so a full request queue still accepts responses, and the reverse.
- R7: A dequeue while both queues are empty changes nothing.
- R8: An enqueue and a dequeue on the same non-empty, non-full queue in one cycle are both performed, and the occupancy is unchanged.
- R9: When the head shows a request, head_data_valid_o is 0 and head_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request enqueue strobe |
| req_ready_o | output | 1 | Request queue not full |
| req_child_i | input | CHILD_W | Request child ID |
| req_addr_i | input | ADDR_W | Request line address |
| req_state_i | input | 2 | Request MSI state |
| rsp_valid_i | input | 1 | Response enqueue strobe |
| rsp_ready_o | output | 1 | Response queue not full |
| rsp_child_i | input | CHILD_W | Response child ID |
| rsp_addr_i | input | ADDR_W | Response line address |
| rsp_state_i | input | 2 | Response MSI state |
| rsp_data_valid_i | input | 1 | Response carries line data |
| rsp_data_i | input | LINE_W | Response line data |
| deq_i | input | 1 | Remove the head message |
| head_is_rsp_o | output | 1 | Head is a response (1) or a request (0) |
| head_child_o | output | CHILD_W | Head child ID |
| head_addr_o | output | ADDR_W | Head line address |
| head_state_o | output | 2 | Head MSI state |
| head_data_valid_o | output | 1 | Head line data valid |
| head_data_o | output | LINE_W | Head line data |
| has_rsp_o | output | 1 | Response queue non-empty |
| has_req_o | output | 1 | Request queue non-empty |
| not_empty_o | output | 1 | Any message present |

## Verification
The hardest case to reach is a full request queue that must still take a response and hand it out first. The dequeue strobe has to stay idle long enough for the request side to saturate while responses keep arriving. The bench drives this with a directed sequence: it fills the request queue to DEPTH, enqueues responses behind it, and then drains everything in order. A random phase follows in which the dequeue rate is deliberately kept low against bursty enqueues. This makes both queues full, simultaneous enqueue and dequeue, and dequeue while empty all recur many times.

// File: rtl/coh_msg_pkg.sv
package coh_msg_pkg;
  parameter int CHILD_W = 2;
  parameter int ADDR_W  = 16;
  parameter int LINE_W  = 32;

  typedef enum logic [1:0] {
    MSI_I = 2'd0,
    MSI_S = 2'd1,
    MSI_M = 2'd2
  } msi_e;

  typedef struct packed {
    logic [CHILD_W-1:0] child;
    logic [ADDR_W-1:0]  addr;
    msi_e               state;
  } req_msg_t;

  typedef struct packed {
    logic [CHILD_W-1:0] child;
    logic [ADDR_W-1:0]  addr;
    msi_e               state;
    logic               data_valid;
    logic [LINE_W-1:0]  data;
  } rsp_msg_t;

  localparam int REQ_W = $bits(req_msg_t);
  localparam int RSP_W = $bits(rsp_msg_t);
endpackage

// File: rtl/msg_fifo.sv
module msg_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic             full_o,
  input  logic             pop_i,
  output logic             empty_o,
  output logic [WIDTH-1:0] head_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_acc, pop_acc;

  assign full_o   = (cnt_q == FULL_CNT);
  assign empty_o  = (cnt_q == '0);
  assign push_acc = push_i && !full_o;
  assign pop_acc  = pop_i && !empty_o;
  assign head_o   = empty_o ? '0 : mem_q[rptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_acc) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop_acc)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_acc) - CNT_W'(pop_acc);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_acc) mem_q[wptr_q] <= push_data_i;
  end

  // R6 / R8: occupancy follows accepted pushes and pops
  a_r8_count_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cnt_q == $past(cnt_q + CNT_W'(push_acc) - CNT_W'(pop_acc)));
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> cnt_q <= FULL_CNT);
  // R7: pop on empty leaves read pointer alone
  a_r7_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o) |=> $stable(rptr_q));
endmodule

// File: rtl/msg_head_sel.sv
module msg_head_sel
  import coh_msg_pkg::*;
(
  input  logic     deq_i,
  input  logic     req_empty_i,
  input  logic     rsp_empty_i,
  input  req_msg_t req_head_i,
  input  rsp_msg_t rsp_head_i,
  output logic     pop_req_o,
  output logic     pop_rsp_o,
  output logic     head_is_rsp_o,
  output rsp_msg_t head_o
);
  assign head_is_rsp_o = !rsp_empty_i;
  assign pop_rsp_o     = deq_i && !rsp_empty_i;
  assign pop_req_o     = deq_i && rsp_empty_i && !req_empty_i;

  always_comb begin
    head_o = '0;
    if (!rsp_empty_i) begin
      head_o = rsp_head_i;
    end else if (!req_empty_i) begin
      head_o.child = req_head_i.child;
      head_o.addr  = req_head_i.addr;
      head_o.state = req_head_i.state;
    end
  end

  // R4: never pop both classes at once
  a_r4_single_pop: assert property (@(posedge deq_i) 1'b1 |-> $onehot0({pop_req_o, pop_rsp_o}))
    else $error("two pops");
endmodule

// File: rtl/coh_msg_queue.sv
module coh_msg_queue
  import coh_msg_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [CHILD_W-1:0] req_child_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [1:0]         req_state_i,
  input  logic               rsp_valid_i,
  output logic               rsp_ready_o,
  input  logic [CHILD_W-1:0] rsp_child_i,
  input  logic [ADDR_W-1:0]  rsp_addr_i,
  input  logic [1:0]         rsp_state_i,
  input  logic               rsp_data_valid_i,
  input  logic [LINE_W-1:0]  rsp_data_i,
  input  logic               deq_i,
  output logic               head_is_rsp_o,
  output logic [CHILD_W-1:0] head_child_o,
  output logic [ADDR_W-1:0]  head_addr_o,
  output logic [1:0]         head_state_o,
  output logic               head_data_valid_o,
  output logic [LINE_W-1:0]  head_data_o,
  output logic               has_rsp_o,
  output logic               has_req_o,
  output logic               not_empty_o
);
  req_msg_t req_in, req_head;
  rsp_msg_t rsp_in, rsp_head, head;
  logic req_full, req_empty, rsp_full, rsp_empty;
  logic pop_req, pop_rsp;

  always_comb begin
    req_in.child = req_child_i;
    req_in.addr  = req_addr_i;
    req_in.state = msi_e'(req_state_i);
    rsp_in.child      = rsp_child_i;
    rsp_in.addr       = rsp_addr_i;
    rsp_in.state      = msi_e'(rsp_state_i);
    rsp_in.data_valid = rsp_data_valid_i;
    rsp_in.data       = rsp_data_i;
  end

  msg_fifo #(.WIDTH(REQ_W), .DEPTH(DEPTH)) u_req_fifo (
    .clk_i, .rst_ni,
    .push_i(req_valid_i), .push_data_i(req_in), .full_o(req_full),
    .pop_i(pop_req), .empty_o(req_empty), .head_o(req_head)
  );

  msg_fifo #(.WIDTH(RSP_W), .DEPTH(DEPTH)) u_rsp_fifo (
    .clk_i, .rst_ni,
    .push_i(rsp_valid_i), .push_data_i(rsp_in), .full_o(rsp_full),
    .pop_i(pop_rsp), .empty_o(rsp_empty), .head_o(rsp_head)
  );

  msg_head_sel u_sel (
    .deq_i, .req_empty_i(req_empty), .rsp_empty_i(rsp_empty),
    .req_head_i(req_head), .rsp_head_i(rsp_head),
    .pop_req_o(pop_req), .pop_rsp_o(pop_rsp),
    .head_is_rsp_o, .head_o(head)
  );

  assign req_ready_o       = !req_full;
  assign rsp_ready_o       = !rsp_full;
  assign has_req_o         = !req_empty;
  assign has_rsp_o         = !rsp_empty;
  assign not_empty_o       = has_req_o || has_rsp_o;
  assign head_child_o      = head.child;
  assign head_addr_o       = head.addr;
  assign head_state_o      = head.state;
  assign head_data_valid_o = head.data_valid;
  assign head_data_o       = head.data;

  // R3: a waiting response stays at the head until dequeued
  a_r3_rsp_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (has_rsp_o && !deq_i) |=> head_is_rsp_o && $stable(head_addr_o) && $stable(head_data_o));
  // R4: dequeue with a response present leaves request side untouched
  a_r4_req_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_i && has_rsp_o && !req_valid_i) |=> has_req_o == $past(has_req_o));
  // R7: dequeue on empty with no enqueue keeps everything empty
  a_r7_empty_deq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deq_i && !not_empty_o && !req_valid_i && !rsp_valid_i) |=> !not_empty_o);
  // R9: request heads carry no line data
  a_r9_req_no_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (not_empty_o && !head_is_rsp_o) |-> !head_data_valid_o && head_data_o == '0);
endmodule

// File: tb/coh_msg_queue_bench.sv
module coh_msg_queue_bench;
  import coh_msg_pkg::*;
  localparam int DEPTH = 4;
  localparam int QW = CHILD_W + ADDR_W + 2;
  localparam int SW = QW + 1 + LINE_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, rsp_valid = 0, deq = 0, rsp_dv = 0;
  logic [CHILD_W-1:0] req_child = 0, rsp_child = 0;
  logic [ADDR_W-1:0] req_addr = 0, rsp_addr = 0;
  logic [1:0] req_state = 0, rsp_state = 0;
  logic [LINE_W-1:0] rsp_data = 0;
  logic req_ready, rsp_ready, head_is_rsp, head_dv, has_rsp, has_req, not_empty;
  logic [CHILD_W-1:0] head_child;
  logic [ADDR_W-1:0] head_addr;
  logic [1:0] head_state;
  logic [LINE_W-1:0] head_data;

  coh_msg_queue #(.DEPTH(DEPTH)) u_coh_msg_queue (
    .clk_i(clk), .rst_ni,
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_child_i(req_child),
    .req_addr_i(req_addr), .req_state_i(req_state),
    .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready), .rsp_child_i(rsp_child),
    .rsp_addr_i(rsp_addr), .rsp_state_i(rsp_state), .rsp_data_valid_i(rsp_dv),
    .rsp_data_i(rsp_data), .deq_i(deq),
    .head_is_rsp_o(head_is_rsp), .head_child_o(head_child), .head_addr_o(head_addr),
    .head_state_o(head_state), .head_data_valid_o(head_dv), .head_data_o(head_data),
    .has_rsp_o(has_rsp), .has_req_o(has_req), .not_empty_o(not_empty)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  logic [QW-1:0] rq[$];
  logic [SW-1:0] sq[$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_req_ready();
    return rq.size() < DEPTH;
  endfunction
  function automatic logic exp_rsp_ready();
    return sq.size() < DEPTH;
  endfunction

  // compare all outputs against the model; called away from the clock edge
  task automatic check_all();
    chk("R5 has_rsp", 64'(has_rsp), 64'(sq.size() != 0));
    chk("R5 has_req", 64'(has_req), 64'(rq.size() != 0));
    chk("R5 not_empty", 64'(not_empty), 64'(sq.size() != 0 || rq.size() != 0));
    chk("R6 req_ready", 64'(req_ready), 64'(exp_req_ready()));
    chk("R6 rsp_ready", 64'(rsp_ready), 64'(exp_rsp_ready()));
    if (sq.size() != 0) begin
      chk("R3 head_is_rsp", 64'(head_is_rsp), 64'd1);
      chk("R2 rsp head", 64'({head_child, head_addr, head_state, head_dv, head_data}),
          64'(sq[0]));
    end else if (rq.size() != 0) begin
      chk("R3 head_is_rsp", 64'(head_is_rsp), 64'd0);
      chk("R1 req head", 64'({head_child, head_addr, head_state}), 64'(rq[0]));
      chk("R9 req no data", 64'({head_dv, head_data}), 64'd0);
    end
  endtask

  // one cycle: drive inputs after negedge, model the edge, check at next negedge
  task automatic step(bit rv, bit sv, bit dq);
    logic [QW-1:0] rmsg;
    logic [SW-1:0] smsg;
    bit racc, sacc;
    req_valid = rv; rsp_valid = sv; deq = dq;
    req_child = CHILD_W'($urandom); req_addr = ADDR_W'($urandom);
    req_state = 2'($urandom_range(0, 2));
    rsp_child = CHILD_W'($urandom); rsp_addr = ADDR_W'($urandom);
    rsp_state = 2'($urandom_range(0, 2)); rsp_dv = 1'($urandom);
    rsp_data = LINE_W'($urandom);
    rmsg = {req_child, req_addr, req_state};
    smsg = {rsp_child, rsp_addr, rsp_state, rsp_dv, rsp_data};
    racc = rv && (rq.size() < DEPTH);
    sacc = sv && (sq.size() < DEPTH);
    @(posedge clk);
    if (dq) begin
      if (sq.size() != 0) void'(sq.pop_front());
      else if (rq.size() != 0) void'(rq.pop_front());
    end
    if (racc) rq.push_back(rmsg);
    if (sacc) sq.push_back(smsg);
    @(negedge clk);
    req_valid = 0; rsp_valid = 0; deq = 0;
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R5: reset state
    chk("R5 reset not_empty", 64'(not_empty), 64'd0);
    chk("R6 reset ready", 64'({req_ready, rsp_ready}), 64'd3);
    rst_ni = 1'b1;
    @(negedge clk);
    // R7: dequeue on empty ignored
    step(0, 0, 1);
    chk("R7 empty deq", 64'(not_empty), 64'd0);
    // R6: fill request queue, then responses still accepted
    for (int i = 0; i < DEPTH + 1; i++) step(1, 0, 0);
    chk("R6 req full", 64'(req_ready), 64'd0);
    step(0, 1, 0);
    chk("R6 rsp accepted behind full req", 64'(has_rsp), 64'd1);
    step(0, 1, 0);
    // R4: responses leave first, then requests in order
    chk("R4 rsp first", 64'(head_is_rsp), 64'd1);
    for (int i = 0; i < 2; i++) step(0, 0, 1);
    chk("R4 req after rsps", 64'(head_is_rsp), 64'd0);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1);
    chk("R7 drained", 64'(not_empty), 64'd0);
    // R8: simultaneous enq/deq on one queue
    step(1, 0, 0);
    step(1, 0, 1);
    chk("R8 req occupancy", 64'(has_req), 64'd1);
    step(0, 1, 0);
    step(0, 1, 1);
    chk("R8 rsp occupancy", 64'(has_rsp), 64'd1);
    // random phase, low dequeue rate to reach full queues
    for (int i = 0; i < 3000; i++)
      step(($urandom_range(0, 99) < 45), ($urandom_range(0, 99) < 35),
           ($urandom_range(0, 99) < 60));
    for (int i = 0; i < 3 * DEPTH; i++) step(0, 0, 1);
    chk("R4 final drain", 64'(not_empty), 64'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule